// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a 1024-word by 8-bit memory with two symmetric, fully independent synchronous ports called left and right. Each port has an active-low select, an active-low output enable, a read/write strobe (low means write), an address, a write-data bus and a registered read-data bus. Both ports can read or write any word in the same cycle. A port whose select is high is in standby. It makes no access, and its read-data bus keeps its last value.

On top of the storage sits a doorbell scheme between the two ports. The word at address 0x3FE is the inbox of the left port, and the word at 0x3FF is the inbox of the right port. When one port writes into the other port's inbox, that port's active-low interrupt output goes low and stays low. The receiving port lowers the flag again by selecting its own inbox with output enable low. The stored byte is ordinary data that the hardware never decodes. A mode input turns the doorbell scheme on or off. When it is off, both words are plain RAM and both interrupt outputs stay high.

Each flag is held by a small two-state machine:
- `MB_IDLE`: no message pending. The interrupt output is high.
- `MB_PEND`: a message is pending. The interrupt output is low.

Its transitions are:
- `arm`: `MB_IDLE` to `MB_PEND`, taken on a set request.
- `ack`: `MB_PEND` to `MB_IDLE`, taken on a clear request with no set in the same cycle.
- `hold`: stay in the current state when no request applies.
- `off`: any state to `MB_IDLE`, taken whenever the mode input is low.

Top module: `dpm_mailbox`

## Requirements
- R1: A write on either port (select low, strobe low) stores the write data at the addressed word. A read (select low, strobe high) puts the addressed word on that port's read-data bus after the next rising clock edge.
- R2: Both ports can access different words in the same cycle, each with its own read or write, without affecting the other.
- R3: A port's read-data bus changes only on a read access of that port. It holds its value while the port is in standby and while the port writes. A port in standby stores nothing, whatever its strobe and data inputs are.
- R4: With the mode input high, a right-port write to 0x3FE drives the left interrupt output low after that clock edge. The output stays low until the left port clears it.
- R5: The left port clears its flag by accessing 0x3FE with select low and output enable low, with the strobe at either level. An access with output enable high does not clear the flag.
- R6: With the mode input high, a left-port write to 0x3FF drives the right interrupt output low. The right port clears it by accessing 0x3FF with select and output enable low, with the strobe at either level.
- R7: The byte written to an inbox is stored unchanged and can be read back by either port.
- R8: With the mode input low, both interrupt outputs are high and no write sets them. A flag that was pending is dropped, and 0x3FE and 0x3FF act as ordinary words.
- R9: If a flag is set and cleared in the same cycle, the set wins and the flag stays low.
- R10: After reset both interrupt outputs are high and both read-data buses are zero.
- R11: If one port reads a word in the same cycle that the other port writes it, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_on | input | 1 | High enables the doorbell scheme |
| l_sel_n | input | 1 | Left port select, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_wr_n | input | 1 | Left port strobe, low means write |
| l_addr | input | 10 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_wr_n | input | 1 | Right port strobe, low means write |
| r_addr | input | 10 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The properties assume that every control input is a known level at each rising edge. They also assume the mode input changes only between edges. Both ports writing the same word in the same cycle is collision territory and is left unspecified. The bench drives every input one nanosecond after a rising edge and holds it stable until the next one. It keeps all controls at defined levels. It never writes the same address from both ports in one cycle, so the checked behaviour always stays inside these assumptions.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    parameter int unsigned DPM_ADDR_W = 10;
    parameter int unsigned DPM_DATA_W = 8;

    typedef enum logic {
        MB_IDLE = 1'b0,
        MB_PEND = 1'b1
    } mbox_state_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic clr_own;
        logic set_peer;
    } port_act_t;

endpackage

// File: rtl/dpm_port_ctl.sv
module dpm_port_ctl
    import dpm_pkg::*;
#(
    parameter int unsigned ADDR_W   = DPM_ADDR_W,
    parameter int unsigned OWN_BOX  = 0,
    parameter int unsigned PEER_BOX = 1
) (
    input  logic              mbox_on,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output port_act_t         act
);

    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

    logic access;
    logic hit_own;
    logic hit_peer;

    always_comb begin
        access   = !sel_n;
        hit_own  = (addr == OWN_A);
        hit_peer = (addr == PEER_A);

        act.wr       = access && !wr_n;
        act.rd       = access && wr_n;
        act.clr_own  = mbox_on && access && !oe_n && hit_own;
        act.set_peer = mbox_on && access && !wr_n && hit_peer;
    end

endmodule

// File: rtl/dpm_mbox_fsm.sv
module dpm_mbox_fsm
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    mbox_state_e state_q;
    mbox_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = MB_IDLE;
        end else begin
            unique case (state_q)
                MB_IDLE: if (set_req) state_d = MB_PEND;
                MB_PEND: if (clr_req && !set_req) state_d = MB_IDLE;
                default: state_d = MB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MB_IDLE: irq_n = 1'b1;
            MB_PEND: irq_n = 1'b0;
            default: irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_wr) mem[a_addr] <= a_wdata;
        if (b_wr) mem[b_addr] <= b_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= mem[a_addr];
            if (b_rd) b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
    import dpm_pkg::*;
#(
    parameter int unsigned ADDR_W = DPM_ADDR_W,
    parameter int unsigned DATA_W = DPM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_on,
    input  logic              l_sel_n,
    input  logic              l_oe_n,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_sel_n,
    input  logic              r_oe_n,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam int unsigned LEFT_BOX  = DEPTH - 2;
    localparam int unsigned RIGHT_BOX = DEPTH - 1;

    port_act_t l_act;
    port_act_t r_act;

    dpm_port_ctl #(
        .ADDR_W  (ADDR_W),
        .OWN_BOX (LEFT_BOX),
        .PEER_BOX(RIGHT_BOX)
    ) u_lctl (
        .mbox_on(mbox_on),
        .sel_n  (l_sel_n),
        .oe_n   (l_oe_n),
        .wr_n   (l_wr_n),
        .addr   (l_addr),
        .act    (l_act)
    );

    dpm_port_ctl #(
        .ADDR_W  (ADDR_W),
        .OWN_BOX (RIGHT_BOX),
        .PEER_BOX(LEFT_BOX)
    ) u_rctl (
        .mbox_on(mbox_on),
        .sel_n  (r_sel_n),
        .oe_n   (r_oe_n),
        .wr_n   (r_wr_n),
        .addr   (r_addr),
        .act    (r_act)
    );

    dpm_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_wr   (l_act.wr),
        .a_rd   (l_act.rd),
        .a_addr (l_addr),
        .a_wdata(l_wdata),
        .a_rdata(l_rdata),
        .b_wr   (r_act.wr),
        .b_rd   (r_act.rd),
        .b_addr (r_addr),
        .b_wdata(r_wdata),
        .b_rdata(r_rdata)
    );

    dpm_mbox_fsm u_lflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mbox_on),
        .set_req(r_act.set_peer),
        .clr_req(l_act.clr_own),
        .irq_n  (l_irq_n)
    );

    dpm_mbox_fsm u_rflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mbox_on),
        .set_req(l_act.set_peer),
        .clr_req(r_act.clr_own),
        .irq_n  (r_irq_n)
    );

endmodule

// File: rtl/dpm_mailbox_chk.sv
module dpm_mailbox_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbox_on,
    input logic              l_sel_n,
    input logic              l_oe_n,
    input logic              l_wr_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_sel_n,
    input logic              r_oe_n,
    input logic              r_wr_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] LBOX = ADDR_W'((1 << ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] RBOX = ADDR_W'((1 << ADDR_W) - 1);

    logic l_set, l_clr, r_set, r_clr;
    assign l_set = mbox_on && !r_sel_n && !r_wr_n && (r_addr == LBOX);
    assign l_clr = !l_sel_n && !l_oe_n && (l_addr == LBOX);
    assign r_set = mbox_on && !l_sel_n && !l_wr_n && (l_addr == RBOX);
    assign r_clr = !r_sel_n && !r_oe_n && (r_addr == RBOX);

    p_hold_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel_n || !l_wr_n) |=> $stable(l_rdata));
    p_hold_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel_n || !r_wr_n) |=> $stable(r_rdata));
    p_set_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_set |=> !l_irq_n);
    p_sticky_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_on && !l_irq_n && !l_clr) |=> !l_irq_n);
    p_quiet_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !l_set) |=> l_irq_n);
    p_clear_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_clr && !l_set) |=> l_irq_n);
    p_set_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_set |=> !r_irq_n);
    p_sticky_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_on && !r_irq_n && !r_clr) |=> !r_irq_n);
    p_clear_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_clr && !r_set) |=> r_irq_n);
    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_on |=> (l_irq_n && r_irq_n));
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_set && l_clr) |=> !l_irq_n);

endmodule

bind dpm_mailbox dpm_mailbox_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mbox_on(mbox_on),
    .l_sel_n(l_sel_n),
    .l_oe_n (l_oe_n),
    .l_wr_n (l_wr_n),
    .l_addr (l_addr),
    .l_rdata(l_rdata),
    .l_irq_n(l_irq_n),
    .r_sel_n(r_sel_n),
    .r_oe_n (r_oe_n),
    .r_wr_n (r_wr_n),
    .r_addr (r_addr),
    .r_rdata(r_rdata),
    .r_irq_n(r_irq_n)
);

// File: tb/dpm_mailbox_test.sv
`timescale 1ns/1ps
module dpm_mailbox_test;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam logic [AW-1:0] LBOX = 10'h3FE;
    localparam logic [AW-1:0] RBOX = 10'h3FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbox_on = 1'b1;
    logic l_sel_n = 1'b1, l_oe_n = 1'b1, l_wr_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic l_irq_n;
    logic r_sel_n = 1'b1, r_oe_n = 1'b1, r_wr_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;
    logic r_irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpm_mailbox uut (
        .clk(clk), .rst_n(rst_n), .mbox_on(mbox_on),
        .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        l_sel_n = 1'b1; l_oe_n = 1'b1; l_wr_n = 1'b1;
        r_sel_n = 1'b1; r_oe_n = 1'b1; r_wr_n = 1'b1;
    endtask

    task automatic lw(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe);
        l_sel_n = 1'b0; l_wr_n = 1'b0; l_oe_n = oe; l_addr = a; l_wdata = d;
    endtask
    task automatic lr(input logic [AW-1:0] a, input logic oe);
        l_sel_n = 1'b0; l_wr_n = 1'b1; l_oe_n = oe; l_addr = a;
    endtask
    task automatic rw(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe);
        r_sel_n = 1'b0; r_wr_n = 1'b0; r_oe_n = oe; r_addr = a; r_wdata = d;
    endtask
    task automatic rr(input logic [AW-1:0] a, input logic oe);
        r_sel_n = 1'b0; r_wr_n = 1'b1; r_oe_n = oe; r_addr = a;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "l_irq_n", l_irq_n, 1);
        chk("R10", "r_irq_n", r_irq_n, 1);
        chk("R10", "l_rdata", l_rdata, 0);
        chk("R10", "r_rdata", r_rdata, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_basic_rw();
        for (int i = 0; i < 8; i++) begin
            lw(AW'(i * 37), DW'(8'hA0 + i), 1'b1);
            rw(AW'(512 + i * 11), DW'(8'h3C ^ i), 1'b1);
            tick();
        end
        idle();
        for (int i = 0; i < 8; i++) begin
            rr(AW'(i * 37), 1'b1);
            lr(AW'(512 + i * 11), 1'b1);
            tick();
            chk("R1", "r_rdata cross read", r_rdata, 8'hA0 + i);
            chk("R2", "l_rdata cross read", l_rdata, 8'h3C ^ i);
        end
        idle();
        lw(10'h000, 8'hFF, 1'b1);
        rw(10'h3FD, 8'h01, 1'b1);
        tick();
        lr(10'h3FD, 1'b1);
        rr(10'h000, 1'b1);
        tick();
        chk("R1", "l_rdata top word", l_rdata, 8'h01);
        chk("R1", "r_rdata word 0", r_rdata, 8'hFF);
        idle();
        tick();
    endtask

    task automatic t_standby();
        lw(10'h055, 8'h77, 1'b1);
        tick();
        lr(10'h055, 1'b1);
        tick();
        chk("R3", "l_rdata before standby", l_rdata, 8'h77);
        l_sel_n = 1'b1; l_wr_n = 1'b0; l_addr = 10'h055; l_wdata = 8'h11;
        tick();
        l_addr = 10'h000;
        l_wr_n = 1'b1;
        tick();
        chk("R3", "l_rdata held in standby", l_rdata, 8'h77);
        lw(10'h066, 8'h22, 1'b1);
        tick();
        chk("R3", "l_rdata held during write", l_rdata, 8'h77);
        idle();
        rr(10'h055, 1'b1);
        tick();
        chk("R3", "no store in standby", r_rdata, 8'h77);
        idle();
        tick();
    endtask

    task automatic t_left_doorbell();
        rw(LBOX, 8'h5A, 1'b1);
        tick();
        idle();
        chk("R4", "l_irq_n after right write", l_irq_n, 0);
        chk("R4", "r_irq_n untouched", r_irq_n, 1);
        repeat (3) tick();
        chk("R4", "l_irq_n sticky", l_irq_n, 0);
        lr(LBOX, 1'b1);
        tick();
        chk("R5", "no clear with oe high", l_irq_n, 0);
        chk("R7", "inbox content", l_rdata, 8'h5A);
        lr(LBOX, 1'b0);
        tick();
        idle();
        chk("R5", "clear by read", l_irq_n, 1);
        rw(LBOX, 8'h6B, 1'b1);
        tick();
        chk("R4", "second set", l_irq_n, 0);
        idle();
        lw(LBOX, 8'h99, 1'b0);
        tick();
        idle();
        chk("R5", "clear by write access", l_irq_n, 1);
        tick();
    endtask

    task automatic t_right_doorbell();
        lw(RBOX, 8'hC3, 1'b1);
        tick();
        idle();
        chk("R6", "r_irq_n after left write", r_irq_n, 0);
        chk("R6", "l_irq_n untouched", l_irq_n, 1);
        rr(RBOX, 1'b1);
        tick();
        chk("R7", "right inbox content", r_rdata, 8'hC3);
        chk("R6", "no clear with oe high", r_irq_n, 0);
        rw(RBOX, 8'h44, 1'b0);
        tick();
        idle();
        chk("R6", "clear by right write access", r_irq_n, 1);
        tick();
    endtask

    task automatic t_set_wins();
        rw(LBOX, 8'h10, 1'b1);
        tick();
        lr(LBOX, 1'b0);
        rw(LBOX, 8'h20, 1'b1);
        tick();
        idle();
        chk("R9", "set beats clear", l_irq_n, 0);
        lr(LBOX, 1'b0);
        tick();
        idle();
        chk("R9", "later clear", l_irq_n, 1);
        tick();
    endtask

    task automatic t_disabled();
        rw(LBOX, 8'h31, 1'b1);
        tick();
        idle();
        chk("R8", "pending before disable", l_irq_n, 0);
        mbox_on = 1'b0;
        tick();
        chk("R8", "pending dropped", l_irq_n, 1);
        rw(LBOX, 8'h42, 1'b1);
        lw(RBOX, 8'h53, 1'b1);
        tick();
        idle();
        chk("R8", "l_irq_n stays high", l_irq_n, 1);
        chk("R8", "r_irq_n stays high", r_irq_n, 1);
        lr(RBOX, 1'b0);
        rr(LBOX, 1'b0);
        tick();
        chk("R8", "3FF as RAM", l_rdata, 8'h53);
        chk("R8", "3FE as RAM", r_rdata, 8'h42);
        idle();
        mbox_on = 1'b1;
        tick();
        chk("R8", "no late flag", l_irq_n, 1);
    endtask

    task automatic t_read_before_write();
        lw(10'h100, 8'hAB, 1'b1);
        tick();
        lr(10'h100, 1'b1);
        rw(10'h100, 8'hCD, 1'b1);
        tick();
        chk("R11", "old value on collision read", l_rdata, 8'hAB);
        r_sel_n = 1'b1; r_wr_n = 1'b1;
        tick();
        chk("R11", "new value after", l_rdata, 8'hCD);
        idle();
        tick();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic_rw();
        t_standby();
        t_left_doorbell();
        t_right_doorbell();
        t_set_wins();
        t_disabled();
        t_read_before_write();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule